// File: doc/BRIEF.md
# Prescaled Modulus Down Counter

This block is a 16-bit down counter driven by a tick that a prescaler derives from the bus clock. The prescaler divides by one of two ratios, 64 or 512. Software sets the counter up through a small word-wide register port with three registers: a control register, a count register and a status register that holds an underflow flag. The flag can drive an interrupt line.

Two run modes are available. In one-shot mode the counter stops when it reaches zero. In modulus mode the counter reloads from its load register on the tick after it reaches zero, which gives a periodic underflow. Every write to the count register stores the value as the new reload value. While the counter is enabled, that write also restarts the count at once. The prescaler ratio chosen in the control register takes effect only when a value is next transferred into the counter. A control bit selects whether reads of the count register return the live count or the stored reload value.

Top module: `dcnt_timer`

## Requirements
- R1: After reset, the control register reads 0x0000, the count register reads 0xFFFF, the status register reads 0x0000 and `irq_o` is 0.
- R2: The control register fields are: bit 7 interrupt enable, bit 6 modulus mode, bit 5 read-select, bit 4 prescaler select, bit 2 counter enable, and bit 1 a write-only force-load strobe. Bits 3, 1 and 0 and bits 15:8 read 0, so writing 0x00FF reads back as 0x00F4.
- R3: While the counter enable is 0, the counter holds 0xFFFF and the prescaler stays at its start. Once enabled, the first decrement comes a full prescale period after the write that set the enable.
- R4: While enabled, the counter decrements by exactly one on each prescaled tick. A tick occurs every 64 bus cycles when the active selection is 0 and every 512 when it is 1.
- R5: With modulus mode 0, a counter at 0x0000 stays at 0x0000.
- R6: With modulus mode 1, the tick that finds the counter at 0x0000 loads it with the load register.
- R7: A write to the count register (address 1) always updates the load register. While enabled, the same write loads the counter in that cycle and restarts the prescaler.
- R8: A change of the prescaler select bit becomes the active division only at the next transfer into the counter: a count write while enabled, a force load, or a modulus reload.
- R9: Writing 1 to control bit 1 while the counter is enabled copies the load register into the counter and restarts the prescaler.
- R10: With read-select 0, a count-register read returns the live count. With read-select 1, it returns the load register.
- R11: Status bit 0 is set on the tick that moves the counter from 0x0001 to 0x0000. Writing 1 to status bit 0 (address 2) clears it, and a set in the same cycle wins over the clear.
- R12: `irq_o` is 1 exactly when the status flag and the interrupt enable bit are both 1.
- R13: A read strobe returns its data on `bus_rdata` in the following cycle. The addresses are 0 for control, 1 for count, 2 for status, and 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Underflow interrupt |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are stable and meaningful whenever a strobe is high. They also assume that reset is held for at least one clock edge before any bus activity. The stimulus drives every strobe for exactly one cycle and changes inputs only on the falling edge. It writes count values no larger than a few dozen, so one-shot runs reach zero and modulus runs wrap within the test. A force-load strobe is sent only as part of a control write, and whether it acts depends on the enable already held in the register, which the stimulus sets in an earlier write.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic [1:0] {
    A_CTL = 2'd0,
    A_CNT = 2'd1,
    A_STS = 2'd2,
    A_RSV = 2'd3
  } reg_addr_e;

  localparam int B_IE  = 7;
  localparam int B_MOD = 6;
  localparam int B_RDS = 5;
  localparam int B_PRE = 4;
  localparam int B_EN  = 2;
  localparam int B_FLD = 1;

  typedef struct packed {
    logic ie;
    logic mod_en;
    logic rd_load;
    logic pre_hi;
    logic en;
  } ctl_t;
endpackage

// File: rtl/dcnt_prescaler.sv
module dcnt_prescaler #(
  parameter int DIV_LO = 64,
  parameter int DIV_HI = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic sel_hi,
  output logic tick
);
  localparam int PW = $clog2(DIV_HI);
  localparam logic [PW-1:0] LAST_LO = PW'(DIV_LO - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(DIV_HI - 1);

  logic [PW-1:0] pcnt;

  assign tick = run && (pcnt == (sel_hi ? LAST_HI : LAST_LO));

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick) pcnt <= '0;
    else                                pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/dcnt_core.sv
module dcnt_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          mod_en,
  input  logic          pre_sel,
  input  logic          tick,
  input  logic          cnt_wr,
  input  logic [CW-1:0] wr_val,
  input  logic          force_ld,
  input  logic          flag_clr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] load,
  output logic          pre_act,
  output logic          flag
);
  localparam logic [CW-1:0] ONES = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic underflow;
  assign underflow = en && !cnt_wr && !force_ld && tick && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= ONES;
      load    <= '0;
      pre_act <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (cnt_wr) load <= wr_val;

      if (!en) begin
        cnt <= ONES;
      end else if (cnt_wr) begin
        cnt     <= wr_val;
        pre_act <= pre_sel;
      end else if (force_ld) begin
        cnt     <= load;
        pre_act <= pre_sel;
      end else if (tick) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (mod_en) begin
          cnt     <= load;
          pre_act <= pre_sel;
        end
      end

      if (underflow)     flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dcnt_regs.sv
module dcnt_regs
  import dcnt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] load,
  input  logic          flag,
  output ctl_t          ctl,
  output logic          cnt_wr,
  output logic          force_ld,
  output logic          flag_clr,
  output logic [CW-1:0] bus_rdata
);
  reg_addr_e adr;
  logic [7:0] ctl_byte;

  assign adr      = reg_addr_e'(bus_addr);
  assign cnt_wr   = bus_wr && (adr == A_CNT);
  assign force_ld = bus_wr && (adr == A_CTL) && bus_wdata[B_FLD];
  assign flag_clr = bus_wr && (adr == A_STS) && bus_wdata[0];

  always_comb begin
    ctl_byte        = '0;
    ctl_byte[B_IE]  = ctl.ie;
    ctl_byte[B_MOD] = ctl.mod_en;
    ctl_byte[B_RDS] = ctl.rd_load;
    ctl_byte[B_PRE] = ctl.pre_hi;
    ctl_byte[B_EN]  = ctl.en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (bus_wr && adr == A_CTL) begin
      ctl.ie      <= bus_wdata[B_IE];
      ctl.mod_en  <= bus_wdata[B_MOD];
      ctl.rd_load <= bus_wdata[B_RDS];
      ctl.pre_hi  <= bus_wdata[B_PRE];
      ctl.en      <= bus_wdata[B_EN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (adr)
        A_CTL:   bus_rdata <= CW'(ctl_byte);
        A_CNT:   bus_rdata <= ctl.rd_load ? load : cnt;
        A_STS:   bus_rdata <= CW'(flag);
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer
  import dcnt_pkg::*;
#(
  parameter int CW     = 16,
  parameter int DIV_LO = 64,
  parameter int DIV_HI = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq_o
);
  ctl_t          ctl;
  logic          cnt_wr, force_ld, flag_clr;
  logic          tick, pre_act, flag_q, restart;
  logic          en_q, mod_q, ie_q;
  logic [CW-1:0] cnt_q, load_q;

  assign en_q    = ctl.en;
  assign mod_q   = ctl.mod_en;
  assign ie_q    = ctl.ie;
  assign restart = en_q && (cnt_wr || force_ld);
  assign irq_o   = flag_q && ie_q;

  dcnt_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cnt(cnt_q), .load(load_q), .flag(flag_q),
    .ctl(ctl), .cnt_wr(cnt_wr), .force_ld(force_ld),
    .flag_clr(flag_clr), .bus_rdata(bus_rdata)
  );

  dcnt_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
    .clk(clk), .rst(rst), .run(en_q), .restart(restart),
    .sel_hi(pre_act), .tick(tick)
  );

  dcnt_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .en(en_q), .mod_en(mod_q),
    .pre_sel(ctl.pre_hi), .tick(tick), .cnt_wr(cnt_wr),
    .wr_val(bus_wdata), .force_ld(force_ld), .flag_clr(flag_clr),
    .cnt(cnt_q), .load(load_q), .pre_act(pre_act), .flag(flag_q)
  );
endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          en_q,
  input logic          mod_q,
  input logic          tick,
  input logic          cnt_wr,
  input logic          force_ld,
  input logic          flag_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] load_q,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic [CW-1:0] bus_rdata
);
  a_r3_disabled_ones: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> cnt_q == {CW{1'b1}});

  a_r3_tick_needs_en: assert property (@(posedge clk) disable iff (rst)
    tick |-> en_q);

  a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
    en_q && tick && cnt_q != '0 && !cnt_wr && !force_ld
      |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r5_oneshot_hold: assert property (@(posedge clk) disable iff (rst)
    en_q && !mod_q && cnt_q == '0 && !cnt_wr && !force_ld |=> cnt_q == '0);

  a_r6_reload: assert property (@(posedge clk) disable iff (rst)
    en_q && mod_q && tick && cnt_q == '0 && !cnt_wr && !force_ld
      |=> cnt_q == $past(load_q));

  a_r11_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick) && $past(cnt_q) == CW'(1));

  a_r2_ctl_reserved: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == 2'd0
      |=> bus_rdata[3] == 1'b0 && bus_rdata[1:0] == 2'b00 && bus_rdata[CW-1:8] == '0);
endmodule

bind dcnt_timer dcnt_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .mod_q(mod_q), .tick(tick),
  .cnt_wr(cnt_wr), .force_ld(force_ld), .flag_q(flag_q),
  .cnt_q(cnt_q), .load_q(load_q), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/tb_dcnt_timer.sv
`timescale 1ns/1ps
module tb_dcnt_timer;
  localparam int CW = 16;
  localparam int DLO = 64;
  localparam int DHI = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic irq_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dcnt_timer #(.CW(CW), .DIV_LO(DLO), .DIV_HI(DHI)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Reference model written from the requirements
  logic m_ie, m_mod, m_rds, m_pre, m_en, m_pact, m_flag;
  logic [CW-1:0] m_cnt, m_load, m_rdata;
  int m_pc;

  function automatic logic [CW-1:0] ctl_image(logic ie, logic md, logic rs, logic pr, logic en);
    return CW'({ie, md, rs, pr, 1'b0, en, 2'b00});
  endfunction

  function automatic bit m_irq();
    return m_flag && m_ie;
  endfunction

  always @(posedge clk) begin
    logic tk, cw, fw, cwr, fclr;
    if (rst) begin
      {m_ie, m_mod, m_rds, m_pre, m_en, m_pact, m_flag} <= '0;
      m_cnt <= '1; m_load <= '0; m_rdata <= '0; m_pc <= 0;
    end else begin
      tk   = m_en && (m_pc == (m_pact ? DHI - 1 : DLO - 1));
      cw   = bus_wr && bus_addr == 2'd1;
      cwr  = bus_wr && bus_addr == 2'd0;
      fw   = cwr && bus_wdata[1];
      fclr = bus_wr && bus_addr == 2'd2 && bus_wdata[0];
      if (bus_rd) begin
        case (bus_addr)
          2'd0: m_rdata <= ctl_image(m_ie, m_mod, m_rds, m_pre, m_en);
          2'd1: m_rdata <= m_rds ? m_load : m_cnt;
          2'd2: m_rdata <= CW'(m_flag);
          default: m_rdata <= '0;
        endcase
      end
      if (cw) m_load <= bus_wdata;
      if (cwr) begin
        m_ie <= bus_wdata[7]; m_mod <= bus_wdata[6]; m_rds <= bus_wdata[5];
        m_pre <= bus_wdata[4]; m_en <= bus_wdata[2];
      end
      if (!m_en) begin
        m_cnt <= '1; m_pc <= 0;
      end else if (cw) begin
        m_cnt <= bus_wdata; m_pact <= m_pre; m_pc <= 0;
      end else if (fw) begin
        m_cnt <= m_load; m_pact <= m_pre; m_pc <= 0;
      end else if (tk) begin
        m_pc <= 0;
        if (m_cnt != 0) m_cnt <= m_cnt - 1'b1;
        else if (m_mod) begin m_cnt <= m_load; m_pact <= m_pre; end
      end else begin
        m_pc <= m_pc + 1;
      end
      if (m_en && !cw && !fw && tk && m_cnt == 1) m_flag <= 1'b1;
      else if (fclr) m_flag <= 1'b0;
    end
  end

  task automatic chk(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [CW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // read, compare with model; optionally also with an absolute value
  task automatic rd(logic [1:0] a, string tag, bit use_abs = 0, logic [CW-1:0] abs_v = '0);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, m_rdata);
    if (use_abs) chk(tag, bus_rdata, abs_v);
  endtask

  task automatic chk_irq(string tag);
    @(negedge clk);
    chk(tag, CW'(irq_o), CW'(m_irq()));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, "R1 ctl", 1, 16'h0000);
    rd(2'd1, "R1 count", 1, 16'hFFFF);
    rd(2'd2, "R1 status", 1, 16'h0000);
    rd(2'd3, "R13 unused addr", 1, 16'h0000);
    chk("R1 irq", CW'(irq_o), 16'h0);

    // R2 layout
    wr(2'd0, 16'h00FF);
    rd(2'd0, "R2 ctl image", 1, 16'h00F4);
    // R3 disabled holds all ones
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0005);
    rd(2'd1, "R3 disabled count", 1, 16'hFFFF);
    // R10 read-select shows the load register
    wr(2'd0, 16'h0020);
    rd(2'd1, "R10 load view", 1, 16'h0005);
    wr(2'd0, 16'h0000);
    rd(2'd1, "R10 live view", 1, 16'hFFFF);

    // R9 force load, R5 one-shot to zero, R11 flag
    wr(2'd0, 16'h0004);
    wr(2'd0, 16'h0006);
    rd(2'd1, "R9 force load", 1, 16'h0005);
    idle(DLO - 5);
    rd(2'd1, "R3 first tick timing", 0);
    idle(400);
    rd(2'd1, "R5 halted", 1, 16'h0000);
    rd(2'd2, "R11 flag set", 1, 16'h0001);
    chk_irq("R12 masked");
    wr(2'd0, 16'h0084);
    chk_irq("R12 asserted");
    chk("R12 asserted abs", CW'(irq_o), 16'h1);
    wr(2'd2, 16'h0001);
    rd(2'd2, "R11 cleared", 1, 16'h0000);
    chk_irq("R12 after clear");

    // R7 count write while enabled
    wr(2'd1, 16'h0009);
    rd(2'd1, "R7 immediate load", 1, 16'h0009);
    for (int i = 0; i < 6; i++) begin idle(30); rd(2'd1, "R4 decrement lo"); end

    // R6 modulus mode
    wr(2'd0, 16'h0044);
    wr(2'd1, 16'h0002);
    for (int i = 0; i < 12; i++) begin idle(40); rd(2'd1, "R6 modulus wrap"); end
    rd(2'd2, "R11 modulus flag");

    // R8 prescaler change pending until a load
    wr(2'd0, 16'h0054);
    for (int i = 0; i < 8; i++) begin idle(50); rd(2'd1, "R8 pending select"); end
    wr(2'd0, 16'h0056);
    for (int i = 0; i < 8; i++) begin idle(200); rd(2'd1, "R8 slow ticks"); end
    wr(2'd0, 16'h0006);
    for (int i = 0; i < 4; i++) begin idle(60); rd(2'd1, "R4 back to fast"); end

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2) begin
        logic [CW-1:0] c;
        c = CW'($urandom) & 16'h00E6;
        if ($urandom_range(0, 3) != 0) c[2] = 1'b1;
        if ($urandom_range(0, 3) != 0) c[4] = 1'b0;
        wr(2'd0, c);
      end else if (op < 4) begin
        wr(2'd1, CW'($urandom_range(0, 24)));
      end else if (op == 4) begin
        wr(2'd2, CW'($urandom_range(0, 1)));
      end else begin
        logic [1:0] a;
        a = 2'($urandom_range(0, 3));
        case (a)
          2'd0: rd(a, "R2 random ctl");
          2'd1: rd(a, "R4 random count");
          2'd2: rd(a, "R11 random status");
          default: rd(a, "R13 random unused");
        endcase
        chk_irq("R12 random irq");
      end
      idle($urandom_range(0, 120));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule